// File: doc/BRIEF.md
# Utility and Fairness Way Partitioner

This block decides how the ways of a shared last-level cache are split among the cores that share it. Each core gets its own way group, so one core's fills never displace another core's lines. The block takes, for each core, a curve of estimated miss rates at every possible way count, the miss rate that core shows when it runs alone, a fairness threshold and a start strobe. It returns a way count per core and a one-cycle done flag.

After start, every core first holds one way. The remaining ways are then handed out one per clock. Each way goes to the core whose miss rate drops the most for that one extra way. A grant is only taken if it keeps the allocation fair. For each core a slowdown ratio X is defined as its shared miss rate over its standalone miss rate, and every pair of cores must have |X_i - X_j| below the threshold. The block compares ratios by cross-multiplication, so it needs no divider. If no core can take the way fairly, the way goes to the core that is currently slowed down the most.

Top module: `uf_way_partitioner`

## Requirements
- R1: While reset is asserted and after it is released, every way count on `alloc_o` reads zero and `done_o` is low until the first accepted start.
- R2: A start seen while the block is idle sets every core's count to one at the next clock edge. From then on, exactly one way is added on each following edge until all ways are assigned.
- R3: `done_o` is high for exactly one cycle, on the cycle whose edge assigned the last way. That is NUM_WAYS-NUM_CORES edges after the start was taken. At that point the counts sum to NUM_WAYS and each count is at least one. If NUM_WAYS equals NUM_CORES, `done_o` rises together with the all-ones load.
- R4: Core c's miss rate with k+1 ways is the field `curve_i[(c*NUM_WAYS+k)*MR_W +: MR_W]`. The gain of a core holding n ways is its miss rate at n ways minus its miss rate at n+1 ways. The gain is signed, so a rising curve gives a negative gain.
- R5: With the candidate's count raised by one, X_c = shared_c/alone_c uses the candidate's miss rate at its new count. `alone_i[c*MR_W +: MR_W]` is core c's standalone miss rate. A grant is fair when every pair (i,j) satisfies |s_i*a_j - s_j*a_i| * 2^FRAC_W < thr_i * a_i * a_j, so `thr_i` is unsigned with FRAC_W fraction bits and the comparison is strict.
- R6: Among the cores whose grant is fair, the way goes to the largest gain, and ties go to the lowest core index.
- R7: If no core's grant is fair, the way goes to the core with the largest current ratio s/a, and ties go to the lowest index. With `thr_i` = 0 this path takes every way.
- R8: A start asserted while ways are still being assigned has no effect on the assignment in progress.
- R9: While idle and without a start, `alloc_o` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new allocation when idle |
| curve_i | input | NUM_CORES*NUM_WAYS*MR_W | Per-core miss rate at 1..NUM_WAYS ways |
| alone_i | input | NUM_CORES*MR_W | Per-core standalone miss rate |
| thr_i | input | THR_W | Fairness threshold, FRAC_W fraction bits |
| alloc_o | output | NUM_CORES*CNT_W | Per-core way count, core c at [c*CNT_W +: CNT_W] |
| done_o | output | 1 | One-cycle pulse when all ways are assigned |

## Verification
The bench uses the default build: four cores, eight ways, 8-bit miss rates and a threshold with four fraction bits. At this size each run has four grant steps, and the bench compares every intermediate way vector against an integer model. This covers several hundred random curve, standalone-rate and threshold combinations, along with flat curves that force index ties, a zero threshold that forces the slowdown fallback, and non-monotone curves that give negative gains. Starts during a run and input changes while idle are applied directly.

// File: rtl/uf_pkg.sv
package uf_pkg;
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_GRANT = 1'b1
    } phase_e;
endpackage

// File: rtl/uf_core_view.sv
module uf_core_view #(
    parameter int NUM_WAYS = 8,
    parameter int MR_W     = 8,
    parameter int CNT_W    = 4
) (
    input  logic [NUM_WAYS*MR_W-1:0] curve_i,
    input  logic [CNT_W-1:0]         count_i,
    output logic [MR_W-1:0]          mr_now_o,
    output logic [MR_W-1:0]          mr_next_o,
    output logic signed [MR_W:0]     gain_o
);
    logic [MR_W-1:0] now_v, next_v;

    always_comb begin
        now_v = curve_i[0 +: MR_W];
        for (int k = 0; k < NUM_WAYS; k++) begin
            if (count_i == CNT_W'(k + 1)) now_v = curve_i[k*MR_W +: MR_W];
        end
        next_v = now_v;
        for (int k = 1; k < NUM_WAYS; k++) begin
            if (count_i == CNT_W'(k)) next_v = curve_i[k*MR_W +: MR_W];
        end
    end

    assign mr_now_o  = now_v;
    assign mr_next_o = next_v;
    assign gain_o    = $signed({1'b0, now_v}) - $signed({1'b0, next_v});
endmodule

// File: rtl/uf_fair_check.sv
module uf_fair_check #(
    parameter int NUM_CORES = 4,
    parameter int MR_W      = 8,
    parameter int THR_W     = 8,
    parameter int FRAC_W    = 4
) (
    input  logic [NUM_CORES*MR_W-1:0] shared_i,
    input  logic [NUM_CORES*MR_W-1:0] alone_i,
    input  logic [THR_W-1:0]          thr_i,
    output logic                      ok_o
);
    localparam int WW = 2*MR_W + THR_W + FRAC_W;

    always_comb begin
        logic [WW-1:0] p, q, d, lhs, rhs;
        ok_o = 1'b1;
        for (int i = 0; i < NUM_CORES; i++) begin
            for (int j = i + 1; j < NUM_CORES; j++) begin
                p   = WW'(shared_i[i*MR_W +: MR_W]) * WW'(alone_i[j*MR_W +: MR_W]);
                q   = WW'(shared_i[j*MR_W +: MR_W]) * WW'(alone_i[i*MR_W +: MR_W]);
                d   = (p > q) ? (p - q) : (q - p);
                lhs = d << FRAC_W;
                rhs = WW'(thr_i) * WW'(alone_i[i*MR_W +: MR_W]) * WW'(alone_i[j*MR_W +: MR_W]);
                if (!(lhs < rhs)) ok_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/uf_argmax.sv
module uf_argmax #(
    parameter int N     = 4,
    parameter int W     = 9,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*W-1:0]   vals_i,
    input  logic [N-1:0]     valid_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             found_o
);
    always_comb begin
        logic signed [W-1:0] best;
        best    = '0;
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (valid_i[i] && (!found_o || $signed(vals_i[i*W +: W]) > best)) begin
                best    = $signed(vals_i[i*W +: W]);
                idx_o   = IDX_W'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/uf_ratio_max.sv
module uf_ratio_max #(
    parameter int N     = 4,
    parameter int MR_W  = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*MR_W-1:0] shared_i,
    input  logic [N*MR_W-1:0] alone_i,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int PW = 2*MR_W;

    always_comb begin
        logic [MR_W-1:0] bs, ba;
        bs    = shared_i[0 +: MR_W];
        ba    = alone_i[0 +: MR_W];
        idx_o = '0;
        for (int i = 1; i < N; i++) begin
            if (PW'(shared_i[i*MR_W +: MR_W]) * PW'(ba) > PW'(bs) * PW'(alone_i[i*MR_W +: MR_W])) begin
                bs    = shared_i[i*MR_W +: MR_W];
                ba    = alone_i[i*MR_W +: MR_W];
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/uf_way_partitioner.sv
module uf_way_partitioner
    import uf_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 8,
    parameter int MR_W      = 8,
    parameter int THR_W     = 8,
    parameter int FRAC_W    = 4,
    parameter int CNT_W     = $clog2(NUM_WAYS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [NUM_CORES*NUM_WAYS*MR_W-1:0] curve_i,
    input  logic [NUM_CORES*MR_W-1:0]         alone_i,
    input  logic [THR_W-1:0]                  thr_i,
    output logic [NUM_CORES*CNT_W-1:0]        alloc_o,
    output logic                              done_o
);
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int EXTRA = NUM_WAYS - NUM_CORES;
    localparam int GW    = MR_W + 1;

    typedef struct packed {
        phase_e                             phase;
        logic [CNT_W-1:0]                   left;
        logic [NUM_CORES-1:0][CNT_W-1:0]    alloc;
        logic                               done;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_CORES*MR_W-1:0] shared_now;
    logic [NUM_CORES*MR_W-1:0] mr_next;
    logic [NUM_CORES*GW-1:0]   gain;
    logic [NUM_CORES-1:0]      fair_ok;
    logic [IDX_W-1:0]          pick_idx, fb_idx, win_idx;
    logic                      pick_found;
    logic                      running;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic signed [MR_W:0]      gain_c;
        logic [NUM_CORES*MR_W-1:0] tent;

        uf_core_view #(
            .NUM_WAYS (NUM_WAYS),
            .MR_W     (MR_W),
            .CNT_W    (CNT_W)
        ) u_view (
            .curve_i   (curve_i[c*NUM_WAYS*MR_W +: NUM_WAYS*MR_W]),
            .count_i   (st_q.alloc[c]),
            .mr_now_o  (shared_now[c*MR_W +: MR_W]),
            .mr_next_o (mr_next[c*MR_W +: MR_W]),
            .gain_o    (gain_c)
        );
        assign gain[c*GW +: GW] = gain_c;

        always_comb begin
            tent = shared_now;
            tent[c*MR_W +: MR_W] = mr_next[c*MR_W +: MR_W];
        end

        uf_fair_check #(
            .NUM_CORES (NUM_CORES),
            .MR_W      (MR_W),
            .THR_W     (THR_W),
            .FRAC_W    (FRAC_W)
        ) u_fair (
            .shared_i (tent),
            .alone_i  (alone_i),
            .thr_i    (thr_i),
            .ok_o     (fair_ok[c])
        );
    end

    uf_argmax #(
        .N     (NUM_CORES),
        .W     (GW),
        .IDX_W (IDX_W)
    ) u_pick (
        .vals_i  (gain),
        .valid_i (fair_ok),
        .idx_o   (pick_idx),
        .found_o (pick_found)
    );

    uf_ratio_max #(
        .N     (NUM_CORES),
        .MR_W  (MR_W),
        .IDX_W (IDX_W)
    ) u_fallback (
        .shared_i (shared_now),
        .alone_i  (alone_i),
        .idx_o    (fb_idx)
    );

    assign win_idx = pick_found ? pick_idx : fb_idx;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    for (int c = 0; c < NUM_CORES; c++) st_d.alloc[c] = CNT_W'(1);
                    if (EXTRA == 0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase = PH_GRANT;
                        st_d.left  = CNT_W'(EXTRA);
                    end
                end
            end
            default: begin
                for (int c = 0; c < NUM_CORES; c++) begin
                    if (win_idx == IDX_W'(c)) st_d.alloc[c] = st_q.alloc[c] + CNT_W'(1);
                end
                st_d.left = st_q.left - CNT_W'(1);
                if (st_q.left == CNT_W'(1)) begin
                    st_d.done  = 1'b1;
                    st_d.phase = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alloc_o = st_q.alloc;
    assign done_o  = st_q.done;
    assign running = (st_q.phase == PH_GRANT);
endmodule

// File: rtl/uf_way_partitioner_chk.sv
module uf_way_partitioner_chk #(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 8,
    parameter int CNT_W     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start_i,
    input logic                       run_i,
    input logic [NUM_CORES*CNT_W-1:0] alloc_i,
    input logic                       done_i
);
    localparam int SUM_W = $clog2(NUM_CORES*NUM_WAYS + 1) + 1;

    logic [SUM_W-1:0] sum;
    logic             floor_ok;

    always_comb begin
        sum      = '0;
        floor_ok = 1'b1;
        for (int c = 0; c < NUM_CORES; c++) begin
            sum = sum + SUM_W'(alloc_i[c*CNT_W +: CNT_W]);
            if (alloc_i[c*CNT_W +: CNT_W] == '0) floor_ok = 1'b0;
        end
    end

    AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done_i |=> !done_i);                              // R3
    AST_DONE_FULL:   assert property (@(posedge clk) disable iff (!rst_n) done_i |-> (sum == SUM_W'(NUM_WAYS) && floor_ok)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) sum <= SUM_W'(NUM_WAYS));                         // R3
    AST_START_LOAD:  assert property (@(posedge clk) disable iff (!rst_n) (!run_i && start_i) |=> (sum == SUM_W'(NUM_CORES) && floor_ok)); // R2
    AST_GRANT_STEP:  assert property (@(posedge clk) disable iff (!rst_n) run_i |=> (sum == $past(sum) + SUM_W'(1)));       // R8
    AST_IDLE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (!run_i && !start_i) |=> $stable(alloc_i));       // R9
endmodule

bind uf_way_partitioner uf_way_partitioner_chk #(
    .NUM_CORES (NUM_CORES),
    .NUM_WAYS  (NUM_WAYS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .run_i   (running),
    .alloc_i (alloc_o),
    .done_i  (done_o)
);

// File: tb/uf_way_partitioner_tb.sv
module uf_way_partitioner_tb;
    localparam int NC     = 4;
    localparam int NW     = 8;
    localparam int MR_W   = 8;
    localparam int THR_W  = 8;
    localparam int FRAC_W = 4;
    localparam int CNT_W  = $clog2(NW + 1);
    localparam int EXTRA  = NW - NC;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      start_i = 1'b0;
    logic [NC*NW*MR_W-1:0]     curve_i = '0;
    logic [NC*MR_W-1:0]        alone_i = '0;
    logic [THR_W-1:0]          thr_i = '0;
    logic [NC*CNT_W-1:0]       alloc_o;
    logic                      done_o;

    int curve [NC][NW];
    int alone [NC];
    int thr;
    int m_alloc [NC];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    uf_way_partitioner #(
        .NUM_CORES (NC), .NUM_WAYS (NW), .MR_W (MR_W), .THR_W (THR_W), .FRAC_W (FRAC_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .curve_i (curve_i),
        .alone_i (alone_i), .thr_i (thr_i), .alloc_o (alloc_o), .done_o (done_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic longint exp_vec();
        longint v = 0;
        for (int c = 0; c < NC; c++) v |= longint'(m_alloc[c]) << (c*CNT_W);
        return v;
    endfunction

    task automatic drive_inputs();
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < NW; k++) curve_i[(c*NW+k)*MR_W +: MR_W] = MR_W'(curve[c][k]);
            alone_i[c*MR_W +: MR_W] = MR_W'(alone[c]);
        end
        thr_i = THR_W'(thr);
    endtask

    // R5: fairness of a tentative shared vector, cross-multiplied
    function automatic bit fair(input int s[NC]);
        for (int i = 0; i < NC; i++)
            for (int j = i + 1; j < NC; j++) begin
                longint d = longint'(s[i]) * alone[j] - longint'(s[j]) * alone[i];
                if (d < 0) d = -d;
                if (!(d * (1 << FRAC_W) < longint'(thr) * alone[i] * alone[j])) return 0;
            end
        return 1;
    endfunction

    // one grant of the reference model; returns 1 when the slowdown fallback was used
    function automatic bit model_step();
        int s[NC];
        int best = -1;
        int best_gain = 0;
        for (int c = 0; c < NC; c++) s[c] = curve[c][m_alloc[c]-1];
        for (int c = 0; c < NC; c++) begin
            int t[NC];
            int g = curve[c][m_alloc[c]-1] - curve[c][m_alloc[c]];   // R4 gain
            t = s;
            t[c] = curve[c][m_alloc[c]];
            if (fair(t) && (best < 0 || g > best_gain)) begin
                best = c;
                best_gain = g;
            end
        end
        if (best >= 0) begin
            m_alloc[best]++;
            return 0;
        end
        best = 0;
        for (int c = 1; c < NC; c++)
            if (longint'(s[c]) * alone[best] > longint'(s[best]) * alone[c]) best = c;
        m_alloc[best]++;
        return 1;
    endfunction

    task automatic run_case(input string tag, input int mid_start);
        @(negedge clk);
        drive_inputs();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < NC; c++) m_alloc[c] = 1;
        check("R2 load", alloc_o, exp_vec());
        check("R3 done early", done_o, 0);
        for (int s = 1; s <= EXTRA; s++) begin
            bit fb;
            if (s == mid_start) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            fb = model_step();
            if (mid_start != 0) check("R8 start ignored", alloc_o, exp_vec());
            else if (fb)        check("R7 fallback", alloc_o, exp_vec());
            else                check(tag, alloc_o, exp_vec());
            check("R3 done timing", done_o, (s == EXTRA) ? 1 : 0);
        end
        @(negedge clk);
        check("R3 done single", done_o, 0);
        check("R9 hold after done", alloc_o, exp_vec());
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset alloc", alloc_o, 0);
        check("R1 reset done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", alloc_o, 0);

        // flat curves, loose threshold: all gains tie, lowest index wins (R6)
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < NW; k++) curve[c][k] = 100;
            alone[c] = 100;
        end
        thr = 255;
        run_case("R6 tie", 0);
        check("R6 tie final", alloc_o, 5 | (1 << 4) | (1 << 8) | (1 << 12));

        // steep curves, loose threshold: pure gain order (R4)
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < NW; k++) curve[c][k] = 200 - k * (5 + 7*c);
            alone[c] = 50;
        end
        thr = 255;
        run_case("R4 gain", 0);

        // zero threshold: fallback to largest slowdown (R7)
        for (int c = 0; c < NC; c++) alone[c] = 20 + 30*c;
        thr = 0;
        run_case("R7 zero thr", 0);

        // start during a run (R8)
        thr = 255;
        run_case("R8", 2);

        // idle, no start: inputs change, counts hold (R9)
        for (int c = 0; c < NC; c++) alone[c] = 7;
        thr = 3;
        @(negedge clk);
        drive_inputs();
        repeat (3) @(negedge clk);
        check("R9 idle hold", alloc_o, exp_vec());

        // random sweep, non-monotone curves give negative gains (R5 fairness)
        for (int n = 0; n < 300; n++) begin
            for (int c = 0; c < NC; c++) begin
                int base = 100 + int'($urandom_range(155));
                for (int k = 0; k < NW; k++) begin
                    int v = base - int'($urandom_range(40)) + 8;
                    if (v < 0) v = 0;
                    if (v > 255) v = 255;
                    curve[c][k] = v;
                    base = v;
                end
                alone[c] = 1 + int'($urandom_range(254));
            end
            thr = int'($urandom_range(255));
            run_case("R5 fair pick", 0);
        end

        report();
    end
endmodule